// File: doc/BRIEF.md
# LSB-first framed bit serializer

This block moves one byte at a time across a single wire. A transmitter takes a byte and a one-cycle send strobe. It raises the line for one marker bit and then shifts the eight data bits out, least significant first. It raises the line for one more marker bit and then drops it low again. Each outgoing bit is the carry that falls out when the data register is rotated right, and the carry starts cleared.

A receiver watches a pin and samples it once per bit period. It waits until it has seen the line low. It then treats the next high sample as the opening marker, clears its shift register and loads an eight-step count. Each of the following eight samples is copied into the carry position and rotated into the top of the register, so the first bit received lands in bit 0. When the eighth bit is in, the receiver presents the byte with a one-cycle valid pulse.

A single divider input sets the bit period in clock cycles, and both sides share the resulting bit tick. The pin is expected to already be synchronous to the clock.

Top module: `ser_link`

## Requirements
- R1: While reset is high and in the first cycle after it, tx_line, tx_busy and rx_valid are all 0.
- R2: After a send strobe accepted while idle, the line goes high for one bit period (the opening marker) at the next bit tick.
- R3: The eight data bits follow the opening marker, each for one bit period, bit 0 of tx_byte first and bit 7 last. For example, 0x41 yields 1,0,0,0,0,0,1,0.
- R4: After bit 7 the line is high for one bit period (the closing marker). It is then low. tx_busy falls in the same cycle the line returns low, and the line is never high while tx_busy is low.
- R5: tx_busy rises in the cycle after an accepted send strobe. A strobe seen while tx_busy is high is ignored: it starts no frame and does not alter the frame in progress.
- R6: The receiver assembles the eight samples that follow a marker, the first sample going to bit 0. In a loop-back, rx_valid is high for exactly one cycle, 9 bit periods after the opening marker starts, with rx_byte equal to the byte sent.
- R7: The receiver accepts an opening marker only after it has sampled the pin low at least once since reset or since its last byte. A pin held high from reset produces no rx_valid.
- R8: One bit period lasts bit_div clock cycles, and a bit_div of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_div | input | DIV_W | Clock cycles per bit (0 treated as 1) |
| tx_byte | input | DATA_W | Byte to send, captured on an accepted strobe |
| tx_send | input | 1 | One-cycle send request |
| tx_line | output | 1 | Serial output line |
| tx_busy | output | 1 | High from the accepted strobe until the line returns low |
| rx_pin | input | 1 | Serial input pin, already synchronous to clk |
| rx_byte | output | DATA_W | Last assembled byte |
| rx_valid | output | 1 | One-cycle pulse when rx_byte is updated |

## Verification
The bench builds the block with its defaults, an 8-bit byte and an 8-bit divider. It drives bit_div values from 0 to 5, which reaches single-cycle bits, the clamp of zero to one, and periods where the free-running tick sits at different phases relative to the send strobe. Loop-back frames with all-zero, all-one, alternating and single-bit patterns check the line waveform cycle by cycle and the timing of the received byte. Direct drive of the pin reaches the receiver's need for a low level before it accepts a marker.

// File: rtl/ser_pkg.sv
package ser_pkg;

    // Number of marker bits wrapped around the data (one before, one after)
    localparam int MARK_BITS = 2;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_ARM,
        TX_SHIFT,
        TX_CLOSE,
        TX_TRAIL
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_WAIT_LOW,
        RX_WAIT_MARK,
        RX_COLLECT
    } rx_state_e;

    // Bits on the wire per frame for a given data width
    function automatic int frame_bits(input int data_w);
        return data_w + MARK_BITS;
    endfunction

endpackage

// File: rtl/ser_tick_gen.sv
module ser_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // A divider of zero behaves as one; >= keeps a shrunken divider from stalling
    assign lim  = (div == '0) ? '0 : div - 1'b1;
    assign tick = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ser_tx.sv
module ser_tx
    import ser_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [DATA_W-1:0] data,
    input  logic              send,
    output logic              line,
    output logic              busy
);
    tx_state_e         state;
    logic [DATA_W-1:0] sh;
    logic              carry;
    logic [CNT_W-1:0]  left;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            sh    <= '0;
            carry <= 1'b0;
            left  <= '0;
            line  <= 1'b0;
            busy  <= 1'b0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (send) begin
                        sh    <= data;
                        carry <= 1'b0;
                        left  <= CNT_W'(DATA_W);
                        busy  <= 1'b1;
                        state <= TX_ARM;
                    end
                end
                TX_ARM: begin
                    if (tick) begin
                        line  <= 1'b1;
                        state <= TX_SHIFT;
                    end
                end
                TX_SHIFT: begin
                    if (tick) begin
                        // rotate right through carry; the bit shifted out drives the line
                        carry <= sh[0];
                        line  <= sh[0];
                        sh    <= {carry, sh[DATA_W-1:1]};
                        left  <= left - 1'b1;
                        if (left == CNT_W'(1)) begin
                            state <= TX_CLOSE;
                        end
                    end
                end
                TX_CLOSE: begin
                    if (tick) begin
                        line  <= 1'b1;
                        state <= TX_TRAIL;
                    end
                end
                TX_TRAIL: begin
                    if (tick) begin
                        line  <= 1'b0;
                        busy  <= 1'b0;
                        state <= TX_IDLE;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ser_rx.sv
module ser_rx
    import ser_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              pin,
    output logic [DATA_W-1:0] data,
    output logic              valid
);
    rx_state_e         state;
    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] sh_next;
    logic [CNT_W-1:0]  left;
    logic              carry_in;

    // sampled level enters the carry position and is rotated into the top
    assign carry_in = pin;
    assign sh_next  = {carry_in, sh[DATA_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_WAIT_LOW;
            sh    <= '0;
            left  <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (state)
                RX_WAIT_LOW: begin
                    if (tick && !pin) begin
                        state <= RX_WAIT_MARK;
                    end
                end
                RX_WAIT_MARK: begin
                    if (tick && pin) begin
                        sh    <= '0;
                        left  <= CNT_W'(DATA_W);
                        state <= RX_COLLECT;
                    end
                end
                RX_COLLECT: begin
                    if (tick) begin
                        sh   <= sh_next;
                        left <= left - 1'b1;
                        if (left == CNT_W'(1)) begin
                            data  <= sh_next;
                            valid <= 1'b1;
                            state <= RX_WAIT_LOW;
                        end
                    end
                end
                default: state <= RX_WAIT_LOW;
            endcase
        end
    end
endmodule

// File: rtl/ser_link.sv
module ser_link #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  bit_div,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_send,
    output logic              tx_line,
    output logic              tx_busy,
    input  logic              rx_pin,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic bit_tick;

    ser_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .div  (bit_div),
        .tick (bit_tick)
    );

    ser_tx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
        .clk  (clk),
        .rst  (rst),
        .tick (bit_tick),
        .data (tx_byte),
        .send (tx_send),
        .line (tx_line),
        .busy (tx_busy)
    );

    ser_rx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .tick  (bit_tick),
        .pin   (rx_pin),
        .data  (rx_byte),
        .valid (rx_valid)
    );
endmodule

// File: rtl/ser_link_chk.sv
module ser_link_chk (
    input logic clk,
    input logic rst,
    input logic tx_send,
    input logic tx_line,
    input logic tx_busy,
    input logic rx_valid
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tx_line && !tx_busy && !rx_valid));

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> $past(tx_send));

    // R4
    line_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> !tx_line);

    // R4
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_busy) |-> $past(tx_line));

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
endmodule

bind ser_link ser_link_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_send  (tx_send),
    .tx_line  (tx_line),
    .tx_busy  (tx_busy),
    .rx_valid (rx_valid)
);

// File: tb/tb_ser_link.sv
`timescale 1ns/1ps
module tb_ser_link;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 8;
    localparam int NVEC   = 6;

    // {byte, divider}
    localparam logic [15:0] VEC [NVEC] = '{
        {8'h41, 8'd4},
        {8'h00, 8'd3},
        {8'hFF, 8'd5},
        {8'hA5, 8'd2},
        {8'h80, 8'd1},
        {8'h01, 8'd0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DIV_W-1:0]  bit_div = 8'd2;
    logic [DATA_W-1:0] tx_byte = '0;
    logic              tx_send = 1'b0;
    logic              tx_line;
    logic              tx_busy;
    logic              rx_pin;
    logic [DATA_W-1:0] rx_byte;
    logic              rx_valid;
    logic              loop_en = 1'b1;
    logic              drv_pin = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    assign rx_pin = loop_en ? tx_line : drv_pin;

    always #10 clk = ~clk;

    ser_link #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dut (
        .clk      (clk),
        .rst      (rst),
        .bit_div  (bit_div),
        .tx_byte  (tx_byte),
        .tx_send  (tx_send),
        .tx_line  (tx_line),
        .tx_busy  (tx_busy),
        .rx_pin   (rx_pin),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic frame_bit(input logic [7:0] b, input int idx);
        if (idx == 0 || idx == 9) return 1'b1;
        return b[idx-1];
    endfunction

    // Sends one byte in loop-back and checks the line cycle by cycle
    task automatic run_frame(input logic [7:0] b, input logic [7:0] div);
        int d;
        int n;
        int bad_line;
        int bad_valid;
        logic [7:0] got;
        logic got_v;
        logic busy_pre;
        logic busy_end;
        logic line_end;
        d = (div == 0) ? 1 : int'(div);
        bit_div = div;
        repeat (40) @(negedge clk);
        tx_byte = b;
        tx_send = 1'b1;
        @(negedge clk);
        tx_send = 1'b0;
        chk(tx_busy == 1'b1, "R5 busy after strobe", tx_busy, 1);
        n = 0;
        while (!tx_line && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(tx_line == 1'b1, "R2 opening marker", tx_line, 1);
        bad_line = -1; bad_valid = 0; got = '0; got_v = 1'b0;
        busy_pre = 1'b0; busy_end = 1'b1; line_end = 1'b1;
        for (int c = 0; c <= 10 * d; c++) begin
            if (c < 10 * d) begin
                if (tx_line !== frame_bit(b, c / d) && bad_line < 0) bad_line = c;
            end else begin
                line_end = tx_line;
                busy_end = tx_busy;
            end
            if (c == 10 * d - 1) busy_pre = tx_busy;
            if (rx_valid !== (c == 9 * d)) bad_valid++;
            if (c == 9 * d) begin
                got_v = rx_valid;
                got = rx_byte;
            end
            if (c < 10 * d) @(negedge clk);
        end
        chk(bad_line < 0, "R2 R3 R8 line sequence (first bad cycle)", bad_line, 32'hFFFFFFFF);
        chk(busy_pre == 1'b1 && busy_end == 1'b0 && line_end == 1'b0,
            "R4 busy falls with line low", {busy_pre, busy_end, line_end}, 3'b100);
        chk(got_v == 1'b1 && bad_valid == 0, "R6 valid single pulse at 9 bits", bad_valid, 0);
        chk(got == b, "R6 received byte", got, b);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        int extra;
        logic [7:0] pat;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!tx_line && !tx_busy && !rx_valid, "R1 during reset", {tx_line, tx_busy, rx_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!tx_line && !tx_busy && !rx_valid, "R1 after reset", {tx_line, tx_busy, rx_valid}, 0);

        for (int i = 0; i < NVEC; i++) begin
            run_frame(VEC[i][15:8], VEC[i][7:0]);
        end

        // R5: strobe during a frame is ignored
        bit_div = 8'd3;
        repeat (40) @(negedge clk);
        tx_byte = 8'h41;
        tx_send = 1'b1;
        @(negedge clk);
        tx_send = 1'b0;
        tx_byte = 8'h3C;
        n = 0;
        while (!tx_line && n < 200) begin
            @(negedge clk);
            n++;
        end
        repeat (5) @(negedge clk);
        tx_send = 1'b1;
        @(negedge clk);
        tx_send = 1'b0;
        n = 0;
        while (!rx_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(rx_valid && rx_byte == 8'h41, "R5 frame unaltered by second strobe", rx_byte, 8'h41);
        n = 0;
        while (tx_busy && n < 200) begin
            @(negedge clk);
            n++;
        end
        extra = 0;
        for (int c = 0; c < 30; c++) begin
            if (tx_line || tx_busy) extra++;
            @(negedge clk);
        end
        chk(extra == 0, "R5 no frame from ignored strobe", extra, 0);

        // R7: pin held high from reset yields nothing
        loop_en = 1'b0;
        drv_pin = 1'b1;
        bit_div = 8'd2;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        extra = 0;
        for (int c = 0; c < 40; c++) begin
            if (rx_valid) extra++;
            @(negedge clk);
        end
        chk(extra == 0, "R7 high pin from reset gives no byte", extra, 0);

        // R7 R6: after a low level, a driven frame 0xC3 is accepted
        pat = 8'hC3;
        drv_pin = 1'b0;
        repeat (4) @(negedge clk);
        extra = 0;
        got_frame: for (int k = 0; k < 11; k++) begin
            drv_pin = (k == 10) ? 1'b0 : frame_bit(pat, k);
            for (int c = 0; c < 2; c++) begin
                @(negedge clk);
                if (rx_valid) begin
                    extra++;
                    chk(rx_byte == pat, "R7 R6 byte after low then marker", rx_byte, pat);
                end
            end
        end
        repeat (6) begin
            @(negedge clk);
            if (rx_valid) begin
                extra++;
                chk(rx_byte == pat, "R7 R6 byte after low then marker", rx_byte, pat);
            end
        end
        chk(extra == 1, "R7 exactly one byte accepted", extra, 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule